// File: doc/BRIEF.md
# Reset Source Capture Controller

This controller merges eight reset request inputs into a single stretched system reset. It also keeps an 8-bit register that tells software which source caused the most recent reset. The requests come from a power-on detect, a supply-monitor trip, an external reset pin, a watchdog overflow, a missing-clock timeout, a clock-alarm or oscillator-failure event, a comparator output and a flash error. Four of these sources can be switched on or off by software. Three always reset the chip. The eighth bit position is a software-triggered reset.

The register interface is a plain write strobe with a per-bit write mask, plus a read bus that is always valid. On the four gateable positions, a write stores an enable, but a read returns the last-reset flag. Because of this, a read-modify-write cannot preserve the enables. The write mask takes its place: software can change one enable without touching the others. Power-on (`por_i`) is the only thing that resets the controller itself. The system reset it produces leaves the flags and enables in place, so software can read them after the reset ends. All request inputs are levels that are synchronous to `clk_i`.

Top module: `rsc_ctrl`

## Requirements
- R1: `rd_data_o` always shows the flag register. The bit positions are: 7 clock alarm, 6 flash error, 5 comparator, 4 software, 3 watchdog, 2 missing clock, 1 power-on/supply monitor, 0 external pin.
- R2: While `por_i` is high, the flags read 0x02, `sys_rst_o` is 1, and only the supply-monitor enable (bit 1) is set. After `por_i` falls, `sys_rst_o` stays high for exactly 16 more cycles.
- R3: The clock-alarm (7), comparator (5), missing-clock (2) and supply-monitor (1) events cause a reset only while their stored enable is 1. When the enable is 0, the event leaves `sys_rst_o` low and the flags unchanged.
- R4: The flash error (6), watchdog (3) and pin (0) always cause a reset. Writes to bits 6, 3 and 0 have no effect.
- R5: A write with mask bit 4 and data bit 4 both set forces a reset, and bit 4 then reads 1. Writing 0 to bit 4 does nothing.
- R6: A request seen while `sys_rst_o` is low replaces all earlier flags. Requests that arrive while `sys_rst_o` is high are added to the flags of the current reset.
- R7: When several sources request in the same cycle, all of their flags are set together.
- R8: Whenever bit 1 is set, every other flag bit reads 0.
- R9: Writing 1 to enable bit 1 while `supmon_stable_i` is 0 causes a supply-monitor reset, which reads as 0x02.
- R10: A write changes only the enables whose `wr_mask_i` bit is 1. All other enables keep their value.
- R11: `sys_rst_o` rises in the cycle after a request is sampled. It then stays high for exactly 16 cycles after the last cycle in which a request was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on detect, asynchronous, active high; resets the controller |
| supmon_trip_i | input | 1 | Supply-monitor trip request |
| supmon_stable_i | input | 1 | Supply monitor has settled |
| pin_rst_i | input | 1 | External reset pin request |
| wdt_ovf_i | input | 1 | Watchdog overflow request |
| mcd_timeout_i | input | 1 | Missing-clock timeout request |
| rtc_evt_i | input | 1 | Clock alarm or oscillator failure request |
| cmp_evt_i | input | 1 | Comparator reset request |
| flash_err_i | input | 1 | Flash error request |
| wr_en_i | input | 1 | Register write strobe |
| wr_mask_i | input | 8 | Per-bit write mask |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Last-reset flags |
| sys_rst_o | output | 1 | Stretched system reset |

## Verification
The bench triggers a gated event while its enable is 0. A design that ignored the enable would raise a reset and overwrite the flags. The bench also writes the enables through the mask, then triggers the other sources. A design that did a full-width write would lose the neighbouring enables, so a later comparator or supply-monitor event would fail to reset. The bench drives two requests in one cycle, and also adds a second request in the middle of an active reset. Here a design that kept only one flag, or that cleared the flags during an episode, would read back the wrong value. Finally, the bench checks the masking of bit 1, the hazard of writing 1 to the supply-monitor enable while the monitor is unstable, and the exact 16-cycle stretch. An off-by-one counter would show up as 15 or 17 cycles.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int REG_W = 8;

  localparam int BIT_RTC   = 7;
  localparam int BIT_FLASH = 6;
  localparam int BIT_CMP   = 5;
  localparam int BIT_SW    = 4;
  localparam int BIT_WDT   = 3;
  localparam int BIT_MCD   = 2;
  localparam int BIT_VMON  = 1;
  localparam int BIT_PIN   = 0;

  // positions whose write stores an enable
  localparam logic [REG_W-1:0] GATED_MASK = 8'hA6;
  // enable value after power-on
  localparam logic [REG_W-1:0] EN_POR     = 8'h02;
  // flag value after power-on
  localparam logic [REG_W-1:0] FLAG_POR   = 8'h02;
endpackage

// File: rtl/rsc_enable_reg.sv
module rsc_enable_reg
  import rsc_pkg::*;
(
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_mask_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] en_o
);
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] upd;

  assign upd = wr_mask_i & GATED_MASK & {REG_W{wr_en_i}};

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) en_q <= EN_POR;
    else       en_q <= (en_q & ~upd) | (wr_data_i & upd);
  end

  assign en_o = en_q;

  // R10
  unmasked_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (!wr_en_i || ((wr_mask_i & GATED_MASK) == '0)) |=> $stable(en_q));
endmodule

// File: rtl/rsc_req_gate.sv
module rsc_req_gate
  import rsc_pkg::*;
(
  input  logic [REG_W-1:0] ev_i,
  input  logic [REG_W-1:0] en_i,
  input  logic             hazard_i,
  output logic [REG_W-1:0] req_o
);
  logic [REG_W-1:0] gated;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (GATED_MASK[i]) begin : g_gated
      assign gated[i] = ev_i[i] & en_i[i];
    end else begin : g_always
      assign gated[i] = ev_i[i];
    end
  end

  always_comb begin
    req_o = gated;
    req_o[BIT_VMON] = gated[BIT_VMON] | hazard_i;
  end
endmodule

// File: rtl/rsc_flag_capture.sv
module rsc_flag_capture
  import rsc_pkg::*;
(
  input  logic             clk_i,
  input  logic             por_i,
  input  logic [REG_W-1:0] req_i,
  input  logic             busy_i,
  output logic [REG_W-1:0] flags_o
);
  logic [REG_W-1:0] flags_q;
  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] nxt;

  always_comb begin
    merged = busy_i ? (flags_q | req_i) : req_i;
    nxt    = merged[BIT_VMON] ? FLAG_POR : merged;
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)       flags_q <= FLAG_POR;
    else if (|req_i) flags_q <= nxt;
  end

  assign flags_o = flags_q;

  // R6
  flags_quiet_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (req_i == '0) |=> $stable(flags_q));

  // R8
  vmon_exclusive_chk: assert property (@(posedge clk_i) disable iff (por_i)
    req_i[BIT_VMON] |=> (flags_q == FLAG_POR));

  // R7
  all_set_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (!req_i[BIT_VMON] && !busy_i && (req_i != '0)) |=> (flags_q == $past(req_i)));
endmodule

// File: rtl/rsc_stretch.sv
module rsc_stretch #(
  parameter int STRETCH_CYCLES = 16
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic req_any_i,
  output logic rst_o
);
  localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)               cnt_q <= CNT_LOAD;
    else if (req_any_i)      cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign rst_o = (cnt_q != '0);

  // R11
  req_asserts_rst_chk: assert property (@(posedge clk_i) disable iff (por_i)
    req_any_i |=> rst_o);

  // R11
  countdown_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (!req_any_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int STRETCH_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             supmon_trip_i,
  input  logic             supmon_stable_i,
  input  logic             pin_rst_i,
  input  logic             wdt_ovf_i,
  input  logic             mcd_timeout_i,
  input  logic             rtc_evt_i,
  input  logic             cmp_evt_i,
  input  logic             flash_err_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_mask_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             sys_rst_o
);
  logic [REG_W-1:0] ev;
  logic [REG_W-1:0] en;
  logic [REG_W-1:0] req;
  logic             hazard;
  logic             sw_fire;

  assign sw_fire = wr_en_i & wr_mask_i[BIT_SW] & wr_data_i[BIT_SW];
  assign hazard  = wr_en_i & wr_mask_i[BIT_VMON] & wr_data_i[BIT_VMON] & ~supmon_stable_i;

  always_comb begin
    ev            = '0;
    ev[BIT_RTC]   = rtc_evt_i;
    ev[BIT_FLASH] = flash_err_i;
    ev[BIT_CMP]   = cmp_evt_i;
    ev[BIT_SW]    = sw_fire;
    ev[BIT_WDT]   = wdt_ovf_i;
    ev[BIT_MCD]   = mcd_timeout_i;
    ev[BIT_VMON]  = supmon_trip_i;
    ev[BIT_PIN]   = pin_rst_i;
  end

  rsc_enable_reg u_en (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .wr_en_i   (wr_en_i),
    .wr_mask_i (wr_mask_i),
    .wr_data_i (wr_data_i),
    .en_o      (en)
  );

  rsc_req_gate u_gate (
    .ev_i     (ev),
    .en_i     (en),
    .hazard_i (hazard),
    .req_o    (req)
  );

  rsc_flag_capture u_flags (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .req_i   (req),
    .busy_i  (sys_rst_o),
    .flags_o (rd_data_o)
  );

  rsc_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_str (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .req_any_i (|req),
    .rst_o     (sys_rst_o)
  );

  // R3
  gated_block_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (!sys_rst_o && ((ev & ~GATED_MASK) == '0) && !hazard && ((ev & en) == '0))
      |=> !sys_rst_o);

  // R5
  sw_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (sw_fire && !sys_rst_o && !req[BIT_VMON]) |=> (sys_rst_o && rd_data_o[BIT_SW]));
endmodule

// File: tb/rsc_ctrl_bench.sv
`timescale 1ns/1ps
module rsc_ctrl_bench;
  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       trip = 0, stable = 1, pin = 0, wdt = 0, mcd = 0, rtc = 0, cmp = 0, flash = 0;
  logic       wr_en = 0;
  logic [7:0] wr_mask = 0, wr_data = 0;
  logic [7:0] rd;
  logic       rst;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  rsc_ctrl u_rsc_ctrl (
    .clk_i(clk), .por_i(por), .supmon_trip_i(trip), .supmon_stable_i(stable),
    .pin_rst_i(pin), .wdt_ovf_i(wdt), .mcd_timeout_i(mcd), .rtc_evt_i(rtc),
    .cmp_evt_i(cmp), .flash_err_i(flash), .wr_en_i(wr_en), .wr_mask_i(wr_mask),
    .wr_data_i(wr_data), .rd_data_o(rd), .sys_rst_o(rst)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic stretch_len(output int n);
    n = 0;
    while (rst && n < 100) begin n++; tick(); end
  endtask

  // sets one source line for one cycle: 0 pin,1 trip,2 mcd,3 wdt,5 cmp,6 flash,7 rtc
  task automatic pulse(int idx);
    case (idx)
      0: pin = 1; 1: trip = 1; 2: mcd = 1; 3: wdt = 1;
      5: cmp = 1; 6: flash = 1; default: rtc = 1;
    endcase
    tick();
    {pin, trip, mcd, wdt, cmp, flash, rtc} = '0;
  endtask

  task automatic wr(logic [7:0] m, logic [7:0] d);
    wr_en = 1; wr_mask = m; wr_data = d;
    tick();
    wr_en = 0; wr_mask = 0; wr_data = 0;
  endtask

  task automatic t_por();
    int n;
    chk("R2 flags during por", rd, 8'h02);
    chk("R2 rst during por", rst, 1);
    por = 0;
    stretch_len(n);
    chk("R2 por stretch", n, 16);
    chk("R1 flags after por", rd, 8'h02);
  endtask

  task automatic t_fixed_sources();
    int n;
    pulse(0);
    chk("R4 pin flag replaces", rd, 8'h01);
    stretch_len(n);
    chk("R11 pin stretch", n, 16);
    pulse(6);
    chk("R4 flash flag", rd, 8'h40);
    stretch_len(n);
    pulse(3);
    chk("R6 wdt replaces flash", rd, 8'h08);
    stretch_len(n);
    wr(8'h49, 8'h49);
    tick();
    chk("R4 write to fixed bits no reset", rst, 0);
    chk("R4 write to fixed bits flags", rd, 8'h08);
  endtask

  task automatic t_gated();
    int n;
    pulse(7);
    tick();
    chk("R3 rtc disabled no reset", rst, 0);
    chk("R3 rtc disabled flags", rd, 8'h08);
    wr(8'h80, 8'h80);
    chk("R1 read shows flag not enable", rd, 8'h08);
    wr(8'h20, 8'h20);
    wr(8'h80, 8'h00);
    tick();
    chk("R10 enable writes no reset", rst, 0);
    pulse(7);
    tick();
    chk("R10 rtc disabled again", rst, 0);
    pulse(5);
    chk("R10 cmp kept enabled", rd, 8'h20);
    stretch_len(n);
    wr(8'h04, 8'h04);
    pulse(2);
    chk("R3 mcd enabled flag", rd, 8'h04);
    stretch_len(n);
  endtask

  task automatic t_sw();
    int n;
    wr(8'h10, 8'h00);
    tick();
    chk("R5 write zero no reset", rst, 0);
    wr(8'h10, 8'h10);
    chk("R5 sw reset rst", rst, 1);
    chk("R5 sw flag", rd, 8'h10);
    stretch_len(n);
    chk("R11 sw stretch", n, 16);
  endtask

  task automatic t_multi();
    int n;
    pin = 1; wdt = 1;
    tick();
    pin = 0; wdt = 0;
    chk("R7 simultaneous flags", rd, 8'h09);
    stretch_len(n);
    pin = 1;
    repeat (3) tick();
    pin = 0; flash = 1;
    tick();
    flash = 0;
    chk("R6 accumulate in episode", rd, 8'h41);
    stretch_len(n);
    chk("R11 stretch after held request", n, 16);
  endtask

  task automatic t_vmon();
    int n;
    trip = 1; pin = 1;
    tick();
    trip = 0; pin = 0;
    chk("R8 bit1 masks others", rd, 8'h02);
    stretch_len(n);
    wr(8'h02, 8'h00);
    pulse(1);
    tick();
    chk("R3 vmon disabled no reset", rst, 0);
    pulse(0);
    chk("R6 pin flag", rd, 8'h01);
    stretch_len(n);
    stable = 0;
    wr(8'h02, 8'h02);
    chk("R9 unstable write resets", rst, 1);
    chk("R9 unstable write flag", rd, 8'h02);
    stretch_len(n);
    stable = 1;
    wr(8'h02, 8'h02);
    tick();
    chk("R9 stable write no reset", rst, 0);
    pulse(1);
    chk("R3 vmon enabled trip", rd, 8'h02);
    stretch_len(n);
  endtask

  initial begin
    repeat (3) tick();
    t_por();
    t_fixed_sources();
    t_gated();
    t_sw();
    t_multi();
    t_vmon();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule